// File: doc/BRIEF.md
# DDR Ten-Bit Transmit Serializer

This block takes a 5-bit parallel transmit bus per channel. Each bus carries one half of a 10-bit code group on the rising edge of its capture clock and the other half on the falling edge. The block joins the two halves into a code group and shifts the group out serially on a per-channel line, one bit for each cycle of `clk`. `clk` is the serial bit clock. The transmit clocks run at one tenth of its rate. They are treated as sampled signals: each passes through a synchronizer, and its edges are detected in the `clk` domain. The data halves are delayed by the same number of stages, so that each half lines up with the clock edge it arrived with.

A mode input picks the capture clock. Either every channel uses its own transmit clock, or every channel uses the transmit clock of the one channel named by `SHARED_CH`. Each channel's capture controller has two states:
- `CAP_WAIT_LO`: a rising edge stores the low half and moves to `CAP_WAIT_HI`.
- `CAP_WAIT_HI`: a falling edge completes the group, pushes it into a two-entry word buffer and returns to `CAP_WAIT_LO`. A rising edge instead replaces the stored low half.

Each lane's serializer has three states:
- `SER_IDLE`: holds the line at the idle level. A buffered word moves it to `SER_PRIME`.
- `SER_PRIME`: waits `PRIME_CYC` cycles of slack, then loads the word and enters `SER_SHIFT`.
- `SER_SHIFT`: sends ten bits. At the last bit it either reloads at once from the buffer or falls back to `SER_IDLE`.

A global loopback input and a per-channel loopback input both force a channel's line to the idle level (1). The block also drives a per-channel receive byte strobe. It is either a divide-by-ten pulse of `clk` or, when rate matching is enabled for that channel, the reference tick.

Top module: `ddr_tbi_serializer`

## Requirements
- R1: During reset and right after it, every `ser_out` bit is 1. The divide-by-ten strobe is low during reset.
- R2: A rising capture-clock edge captures `tx_half` as bits 4..0 of a group. The next falling edge captures `tx_half` as bits 9..5.
- R3: A group is sent least-significant bit first: bit 0, which came with the rising edge, is sent first, followed by bits 1 through 9, one per `clk` cycle.
- R4: When the next group is already buffered as the last bit of a group goes out, the first bit of the next group follows in the very next cycle, with no idle bit between them.
- R5: Starting from idle, `ser_out` stays 1 until a complete group is captured. Bit 0 of that group appears after the 8th rising edge of `clk` that follows the falling-edge transition on the capture clock.
- R6: With `clk_sel` = 1, each channel captures only on its own `tx_clk` bit. A channel whose clock does not toggle keeps `ser_out` at 1.
- R7: With `clk_sel` = 0, `tx_clk[SHARED_CH]` captures data for every channel, and the other `tx_clk` bits are ignored.
- R8: While `lpbk_all` = 1, every `ser_out` bit is 1.
- R9: While `lpbk_ch[i]` = 1, `ser_out[i]` is 1 and the other channels are unaffected.
- R10: With `rate_match_en[i]` = 0, `rx_byte_stb[i]` is a one-cycle pulse. It is high after rising edges 9, 19, 29, and so on, counting edges from the release of reset.
- R11: With `rate_match_en[i]` = 1, `rx_byte_stb[i]` follows `ref_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | 1: each channel uses its own clock; 0: all channels use the clock of `SHARED_CH` |
| tx_clk | input | NCH | Per-channel transmit capture clocks |
| tx_half | input | NCH*HALF_W | Per-channel 5-bit DDR data; channel i in bits [i*5 +: 5] |
| lpbk_all | input | 1 | Global loopback; forces all lines idle |
| lpbk_ch | input | NCH | Per-channel loopback |
| rate_match_en | input | NCH | Per-channel strobe source select |
| ref_tick | input | 1 | Reference-derived byte tick |
| ser_out | output | NCH | Serial output lines |
| rx_byte_stb | output | NCH | Receive byte strobes |

## Verification
The assertions check these properties on every cycle:
- a line is at the idle level whenever its serializer is not shifting;
- both loopback controls force the line idle;
- a buffered word at the last bit always leads straight into the next group;
- the divided strobe never lasts two cycles.

The following can only be shown by the bench's reference model, which compares every line on every clock:
- the half ordering across the two edges;
- the exact bit order;
- the eight-edge startup latency;
- the choice between per-channel and shared capture clocks;
- the exact phase of the strobe.

// File: rtl/tbi_ser_pkg.sv
package tbi_ser_pkg;
    localparam int HALF_W = 5;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [0:0] {
        CAP_WAIT_LO,
        CAP_WAIT_HI
    } cap_state_e;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_PRIME,
        SER_SHIFT
    } ser_state_e;
endpackage

// File: rtl/tbi_half_capture.sv
module tbi_half_capture
    import tbi_ser_pkg::*;
#(
    parameter int HW          = HALF_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_clk,
    input  logic [HW-1:0]   half_in,
    output logic            push,
    output logic [2*HW-1:0] word
);
    localparam int WW = 2 * HW;

    logic [SYNC_STAGES:0] clk_pipe;
    logic [HW-1:0]        data_pipe [SYNC_STAGES];
    logic [HW-1:0]        half_al;
    logic [HW-1:0]        lo_q;
    logic                 edge_rise;
    logic                 edge_fall;
    cap_state_e           state_q;
    cap_state_e           state_d;

    // clock sampler and matching data delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            for (int k = 0; k < SYNC_STAGES; k++) begin
                data_pipe[k] <= '0;
            end
        end else begin
            clk_pipe     <= {clk_pipe[SYNC_STAGES-1:0], cap_clk};
            data_pipe[0] <= half_in;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                data_pipe[k] <= data_pipe[k-1];
            end
        end
    end

    assign half_al   = data_pipe[SYNC_STAGES-1];
    assign edge_rise = clk_pipe[SYNC_STAGES-1] & ~clk_pipe[SYNC_STAGES];
    assign edge_fall = ~clk_pipe[SYNC_STAGES-1] & clk_pipe[SYNC_STAGES];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT_LO;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (edge_rise) begin
                lo_q <= half_al;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_WAIT_LO: if (edge_rise) state_d = CAP_WAIT_HI;
            CAP_WAIT_HI: begin
                if (edge_rise)      state_d = CAP_WAIT_HI;
                else if (edge_fall) state_d = CAP_WAIT_LO;
            end
            default:                state_d = CAP_WAIT_LO;
        endcase
    end

    // outputs
    always_comb begin
        push = (state_q == CAP_WAIT_HI) && edge_fall;
        word = WW'({half_al, lo_q});
    end
endmodule

// File: rtl/tbi_word_fifo2.sv
module tbi_word_fifo2 #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         has_word,
    output logic [W-1:0] head
);
    localparam int DEPTH = 2;

    logic [W-1:0] mem [DEPTH];
    logic         wr_ptr;
    logic         rd_ptr;
    logic [1:0]   count;
    logic         do_push;
    logic         do_pop;

    assign do_pop  = pop && (count != 2'd0);
    assign do_push = push && ((count != 2'd2) || do_pop);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= 1'b0;
            rd_ptr <= 1'b0;
            count  <= 2'd0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= ~wr_ptr;
            end
            if (do_pop) begin
                rd_ptr <= ~rd_ptr;
            end
            count <= count + {1'b0, do_push} - {1'b0, do_pop};
        end
    end

    assign has_word = (count != 2'd0);
    assign head     = mem[rd_ptr];
endmodule

// File: rtl/tbi_lane_serializer.sv
module tbi_lane_serializer
    import tbi_ser_pkg::*;
#(
    parameter int   W         = WORD_W,
    parameter int   PRIME_CYC = 4,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         has_word,
    input  logic [W-1:0] head,
    input  logic         loop_en,
    output logic         pop,
    output logic         ser_bit,
    output logic         shifting,
    output logic         last_bit
);
    localparam int CW = $clog2(W);
    localparam int PW = $clog2(PRIME_CYC + 1);

    ser_state_e    state_q;
    ser_state_e    state_d;
    logic [CW-1:0] bit_cnt;
    logic [PW-1:0] prime_cnt;
    logic [W-1:0]  shreg;
    logic          prime_done;

    assign prime_done = (prime_cnt == PW'(PRIME_CYC - 1));
    assign last_bit   = (state_q == SER_SHIFT) && (bit_cnt == CW'(W - 1));

    // next state
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            SER_IDLE: begin
                if (has_word) state_d = SER_PRIME;
            end
            SER_PRIME: begin
                if (prime_done) begin
                    state_d = SER_SHIFT;
                    pop     = 1'b1;
                end
            end
            SER_SHIFT: begin
                if (last_bit) begin
                    if (has_word) begin
                        state_d = SER_SHIFT;
                        pop     = 1'b1;
                    end else begin
                        state_d = SER_IDLE;
                    end
                end
            end
            default: state_d = SER_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SER_IDLE;
            bit_cnt   <= '0;
            prime_cnt <= '0;
            shreg     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SER_PRIME) begin
                prime_cnt <= prime_cnt + 1'b1;
            end else begin
                prime_cnt <= '0;
            end
            if (pop) begin
                shreg   <= head;
                bit_cnt <= '0;
            end else if (state_q == SER_SHIFT) begin
                shreg   <= {1'b0, shreg[W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        shifting = (state_q == SER_SHIFT);
        if (loop_en || !shifting) begin
            ser_bit = IDLE_LVL;
        end else begin
            ser_bit = shreg[0];
        end
    end
endmodule

// File: rtl/tbi_byte_strobe.sv
module tbi_byte_strobe #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int DW = $clog2(DIV);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == DW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stb = (cnt == DW'(DIV - 1));
endmodule

// File: rtl/ddr_tbi_serializer.sv
module ddr_tbi_serializer
    import tbi_ser_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int HW          = HALF_W,
    parameter int SHARED_CH   = 2,
    parameter int PRIME_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic [NCH-1:0]    tx_clk,
    input  logic [NCH*HW-1:0] tx_half,
    input  logic              lpbk_all,
    input  logic [NCH-1:0]    lpbk_ch,
    input  logic [NCH-1:0]    rate_match_en,
    input  logic              ref_tick,
    output logic [NCH-1:0]    ser_out,
    output logic [NCH-1:0]    rx_byte_stb
);
    localparam int WW = 2 * HW;

    logic [NCH-1:0] cap_clk;
    logic [NCH-1:0] lane_shifting;
    logic [NCH-1:0] lane_last;
    logic [NCH-1:0] lane_has;
    logic           div_stb;

    tbi_byte_strobe #(.DIV(WW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (div_stb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic          push;
        logic [WW-1:0] word;
        logic [WW-1:0] head;
        logic          pop;

        assign cap_clk[i] = clk_sel ? tx_clk[i] : tx_clk[SHARED_CH];

        tbi_half_capture #(.HW(HW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_clk (cap_clk[i]),
            .half_in (tx_half[i*HW +: HW]),
            .push    (push),
            .word    (word)
        );

        tbi_word_fifo2 #(.W(WW)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data (word),
            .pop       (pop),
            .has_word  (lane_has[i]),
            .head      (head)
        );

        tbi_lane_serializer #(.W(WW), .PRIME_CYC(PRIME_CYC), .IDLE_LVL(1'b1)) u_ser (
            .clk      (clk),
            .rst_n    (rst_n),
            .has_word (lane_has[i]),
            .head     (head),
            .loop_en  (lpbk_all | lpbk_ch[i]),
            .pop      (pop),
            .ser_bit  (ser_out[i]),
            .shifting (lane_shifting[i]),
            .last_bit (lane_last[i])
        );

        assign rx_byte_stb[i] = rate_match_en[i] ? ref_tick : div_stb;
    end
endmodule

// File: rtl/tbi_serializer_chk.sv
module tbi_serializer_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lpbk_all,
    input logic [NCH-1:0] lpbk_ch,
    input logic [NCH-1:0] ser_out,
    input logic           div_stb,
    input logic [NCH-1:0] shifting,
    input logic [NCH-1:0] last_bit,
    input logic [NCH-1:0] has_word
);
    // R8
    lpbk_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_all |-> (&ser_out));

    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_stb |=> !div_stb);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R9
        lpbk_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lpbk_ch[i] |-> ser_out[i]);

        // R4
        no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (last_bit[i] && has_word[i]) |=> (shifting[i] && !last_bit[i]));

        // R5
        idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !shifting[i] |-> ser_out[i]);
    end
endmodule

bind ddr_tbi_serializer tbi_serializer_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lpbk_all (lpbk_all),
    .lpbk_ch  (lpbk_ch),
    .ser_out  (ser_out),
    .div_stb  (div_stb),
    .shifting (lane_shifting),
    .last_bit (lane_last),
    .has_word (lane_has)
);

// File: tb/ddr_tbi_serializer_bench.sv
`timescale 1ns/1ps
module ddr_tbi_serializer_bench;
    localparam int NCH = 4;
    localparam int SH  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_sel = 1'b1;
    logic [NCH-1:0]   tx_clk = '0;
    logic [NCH*5-1:0] tx_half = '0;
    logic             lpbk_all = 1'b0;
    logic [NCH-1:0]   lpbk_ch = '0;
    logic [NCH-1:0]   rate_match_en = '0;
    logic             ref_tick = 1'b0;
    logic [NCH-1:0]   ser_out;
    logic [NCH-1:0]   rx_byte_stb;

    always #5 clk = ~clk;

    ddr_tbi_serializer #(.NCH(NCH), .SHARED_CH(SH)) u_ddr_tbi_serializer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tx_clk(tx_clk),
        .tx_half(tx_half), .lpbk_all(lpbk_all), .lpbk_ch(lpbk_ch),
        .rate_match_en(rate_match_en), .ref_tick(ref_tick),
        .ser_out(ser_out), .rx_byte_stb(rx_byte_stb)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    n       = 0;
    int    cyc     = 0;
    string cur_req = "R1";
    bit    done    = 0;

    // reference model state
    logic [9:0] grp [NCH];
    logic [9:0] qw  [NCH][64];
    int         qe  [NCH][64];
    int         qh  [NCH];
    int         qt  [NCH];
    logic [4:0] mlo [NCH];
    bit         mpend [NCH];
    int         mst [NCH];
    int         mpc [NCH];
    int         mbc [NCH];
    logic [9:0] mword [NCH];

    initial begin
        for (int c = 0; c < NCH; c++) begin
            qh[c] = 0; qt[c] = 0; mpend[c] = 0; mst[c] = 0;
            mpc[c] = 0; mbc[c] = 0; mword[c] = '0; mlo[c] = '0;
        end
    end

    // model step then compare, on every clock
    always @(posedge clk) begin
        if (rst_n) begin
            n++;
            for (int c = 0; c < NCH; c++) begin
                bit avail;
                avail = (qh[c] != qt[c]) && (qe[c][qh[c] % 64] < n);
                if (mst[c] == 2) begin
                    if (mbc[c] == 9) begin
                        if (avail) begin
                            mword[c] = qw[c][qh[c] % 64]; qh[c]++; mbc[c] = 0;
                        end else begin
                            mst[c] = 0;
                        end
                    end else begin
                        mbc[c]++;
                    end
                end else if (mst[c] == 1) begin
                    if (mpc[c] == 3) begin
                        mword[c] = qw[c][qh[c] % 64]; qh[c]++; mbc[c] = 0; mst[c] = 2;
                    end else begin
                        mpc[c]++;
                    end
                end else if (avail) begin
                    mst[c] = 1; mpc[c] = 0;
                end
            end
        end
        #1;
        for (int c = 0; c < NCH; c++) begin
            logic  es;
            logic  eb;
            string rq;
            if (lpbk_all || lpbk_ch[c]) begin
                es = 1'b1;
                rq = lpbk_all ? "R8" : "R9";
            end else begin
                es = (mst[c] == 2) ? mword[c][mbc[c]] : 1'b1;
                rq = cur_req;
            end
            eb = rate_match_en[c] ? ref_tick : (rst_n && (n % 10 == 9));
            vectors++;
            if (ser_out[c] !== es) begin
                fails++;
                $display("FAIL %s ser_out[%0d] cycle %0d: got %b expected %b", rq, c, n, ser_out[c], es);
            end
            vectors++;
            if (rx_byte_stb[c] !== eb) begin
                fails++;
                $display("FAIL %s rx_byte_stb[%0d] cycle %0d: got %b expected %b",
                         rate_match_en[c] ? "R11" : "R10", c, n, rx_byte_stb[c], eb);
            end
        end
    end

    // reference tick pattern
    always @(negedge clk) begin
        ref_tick <= ($urandom_range(0, 2) == 0);
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // drive one DDR half; caller sits at a negedge
    task automatic drive_half(input logic [NCH-1:0] mask, input bit rise);
        for (int c = 0; c < NCH; c++) begin
            bit eff;
            tx_half[c*5 +: 5] = rise ? grp[c][4:0] : grp[c][9:5];
            if (mask[c]) tx_clk[c] = rise;
            eff = clk_sel ? mask[c] : mask[SH];
            if (eff) begin
                if (rise) begin
                    mlo[c] = grp[c][4:0]; mpend[c] = 1;
                end else if (mpend[c]) begin
                    qw[c][qt[c] % 64] = {grp[c][9:5], mlo[c]};
                    qe[c][qt[c] % 64] = n + 3;
                    qt[c]++;
                    mpend[c] = 0;
                end
            end
        end
    endtask

    task automatic send_group(input logic [NCH-1:0] mask);
        drive_half(mask, 1'b1);
        repeat (5) @(negedge clk);
        drive_half(mask, 1'b0);
        repeat (5) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int c = 0; c < NCH; c++) begin
            grp[c] = 10'((seed * 37 + c * 113 + 5) ^ (seed << c));
        end
    endtask

    initial begin
        // R1: reset state, idle lines
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (25) @(negedge clk);

        // R2 R3 R5: single group from idle, per-channel clocks
        cur_req = "R5";
        clk_sel = 1'b1;
        grp[0] = 10'b10_0000_0001; grp[1] = 10'b01_1111_1110;
        grp[2] = 10'h155;          grp[3] = 10'h2AA;
        send_group('1);
        repeat (30) @(negedge clk);

        // R4: back-to-back groups with distinct patterns
        cur_req = "R4";
        for (int g = 0; g < 6; g++) begin
            fill(g + 1);
            send_group('1);
        end
        repeat (30) @(negedge clk);

        // R6: only channel 0 clocked in per-channel mode
        cur_req = "R6";
        for (int g = 0; g < 3; g++) begin
            fill(g + 20);
            send_group(4'b0001);
        end
        repeat (30) @(negedge clk);

        // R7: shared clock captures every channel; other clocks ignored
        cur_req = "R7";
        clk_sel = 1'b0;
        for (int g = 0; g < 3; g++) begin
            fill(g + 40);
            send_group(4'b0100);
        end
        repeat (30) @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            fill(g + 50);
            send_group(4'b1011);
        end
        repeat (30) @(negedge clk);

        // R9: one channel looped back while data flows
        cur_req = "R3";
        clk_sel = 1'b1;
        lpbk_ch = 4'b0010;
        for (int g = 0; g < 3; g++) begin
            fill(g + 60);
            send_group('1);
        end
        lpbk_ch = '0;
        repeat (30) @(negedge clk);

        // R8: global loopback
        lpbk_all = 1'b1;
        for (int g = 0; g < 2; g++) begin
            fill(g + 70);
            send_group('1);
        end
        lpbk_all = 1'b0;
        repeat (30) @(negedge clk);

        // R11: reference tick as strobe source; R10 on the rest
        rate_match_en = 4'b1010;
        cur_req = "R2";
        for (int g = 0; g < 3; g++) begin
            fill(g + 80);
            send_group('1);
        end
        repeat (40) @(negedge clk);
        rate_match_en = '0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule